// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers a vector of level interrupt sources and presents two requests to a processor: a normal request and a fast request. Each input first passes through a polarity stage. After that it can be shown either as its live level or as a latched copy that holds until software clears it. Each of the two channels has its own enable set, its own 3-bit priority per source and its own 4-bit threshold. A source can raise its channel's request only when it is enabled, pending, and has a priority value strictly below the threshold.

Software reaches the block through a simple word-indexed register bus. Read data is registered and returns one cycle after the read strobe. Reading the acknowledge register of a channel returns the winning source number. The same read saves the channel's threshold and loads the winner's priority as the new threshold, so the winner and all sources of equal or lower urgency are blocked. Reading the end register of the channel returns the saved value and puts it back as the threshold. Exactly one saved level is kept per channel.

Top module: `intc_top`

## Requirements
- R1: Each polarity bit (address 0x10, reset all ones) passes its input unchanged when 1. When 0 it inverts the input, and the result is the effective level.
- R2: Each source has a latch that sets whenever its effective level is 1. Select bit 1 (address 0x11, reset 0) makes the status view (0x01 for the normal channel, 0x09 for the fast channel) show that latch. Select bit 0 makes the view show the effective level.
- R3: Writing to the status address clears the latched bits where the data is 1. A bit whose effective level is still 1 is set again in the same cycle.
- R4: A write to address 0x02 (0x0A for the fast channel) enables the sources whose data bits are 1. A write to 0x03 (0x0B) disables them. Both addresses read back the channel's enabled set, and the reset state has no source enabled.
- R5: Address 0x00 (0x08) reads the status view ANDed with the channel's enabled set.
- R6: A source is eligible when it is masked-pending and its priority is strictly below the channel's threshold. The threshold resets to 8, is read and written at 0x07 (0x0F), and the channel's request output is high exactly when some source is eligible.
- R7: The winner is the eligible source with the smallest priority value, and a tie goes to the lowest source number. Address 0x04 (0x0C) reads it with no side effect: bit 31 is 1 when a winner exists, and bits 4:0 hold its number.
- R8: Reading 0x05 (0x0D) returns the same word as 0x04. When a winner exists, the read also copies the threshold into the saved register and loads the winner's priority as the new threshold. With no winner, nothing changes.
- R9: Reading 0x06 (0x0E) returns the saved register in bits 3:0 and copies it back into the threshold.
- R10: The fast channel has its own enables, priorities, threshold and saved register. It shares the polarity, the select bits and the latches with the normal channel.
- R11: Priorities are 3-bit and reset to 0. The priority of source s is at 0x40+s for the normal channel and at 0x60+s for the fast channel. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt source levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 7 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Normal-channel request |
| fiq_o | output | 1 | Fast-channel request |

## Verification
The hardest situation to reach from the ports is an acknowledge while a source of better priority is only latched and no longer present at the input. The same applies to an end read after the threshold has been rewritten between the acknowledge and the end. Random stimulus switches source levels, polarity and select bits independently of the bus operations, and it draws priorities from a small range so that ties are frequent. Thresholds are mostly left at their reset value so that requests stay eligible. Directed sequences then build a nested acknowledge and end pair, and a tie between two sources, on the fast channel as well as on the normal one.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int ADDR_W = 7;
    localparam int NUM_CH = 2;

    // low three address bits inside a channel window
    localparam logic [2:0] OFS_MASKED = 3'd0;
    localparam logic [2:0] OFS_STATUS = 3'd1;
    localparam logic [2:0] OFS_EN_SET = 3'd2;
    localparam logic [2:0] OFS_EN_CLR = 3'd3;
    localparam logic [2:0] OFS_CUR    = 3'd4;
    localparam logic [2:0] OFS_ACK    = 3'd5;
    localparam logic [2:0] OFS_END    = 3'd6;
    localparam logic [2:0] OFS_THR    = 3'd7;

    localparam logic [ADDR_W-1:0] ADR_POL  = 7'h10;
    localparam logic [ADDR_W-1:0] ADR_SSEL = 7'h11;

    typedef enum logic {CH_NORM = 1'b0, CH_FAST = 1'b1} chan_e;
endpackage

// File: rtl/intc_cond.sv
module intc_cond #(
    parameter int N = 32
) (
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] ssel_i,
    input  logic [N-1:0] latch_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] view_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign level_o[i] = pol_i[i] ? src_i[i] : ~src_i[i];
        assign view_o[i]  = ssel_i[i] ? latch_i[i] : level_o[i];
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N  = 32,
    parameter int PW = 3,
    parameter int TW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         masked_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    input  logic [TW-1:0]        thr_i,
    output logic                 valid_o,
    output logic [IW-1:0]        id_o,
    output logic [PW-1:0]        prio_o
);
    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        prio_o  = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < N; i++) begin
            if (masked_i[i] && (TW'(prio_i[i]) < thr_i)
                && (!valid_o || (prio_i[i] < prio_o))) begin
                valid_o = 1'b1;
                id_o    = IW'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int THR_W   = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [6:0]         bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int IW = $clog2(NUM_SRC);
    localparam logic [THR_W-1:0] THR_RST = THR_W'(2 ** PRIO_W);

    typedef struct packed {
        logic [NUM_SRC-1:0]                          pol;
        logic [NUM_SRC-1:0]                          ssel;
        logic [NUM_SRC-1:0]                          latch;
        logic [NUM_CH-1:0][NUM_SRC-1:0]              en;
        logic [NUM_CH-1:0][THR_W-1:0]                thr;
        logic [NUM_CH-1:0][THR_W-1:0]                saved;
        logic [NUM_CH-1:0][NUM_SRC-1:0][PRIO_W-1:0]  prio;
        logic [31:0]                                 rdata;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_SRC-1:0]             level, view;
    logic [NUM_CH-1:0][NUM_SRC-1:0] masked;
    logic [NUM_CH-1:0]              win_valid;
    logic [NUM_CH-1:0][IW-1:0]      win_id;
    logic [NUM_CH-1:0][PRIO_W-1:0]  win_prio;

    intc_cond #(.N(NUM_SRC)) i_cond (
        .src_i   (src_i),
        .pol_i   (state_q.pol),
        .ssel_i  (state_q.ssel),
        .latch_i (state_q.latch),
        .level_o (level),
        .view_o  (view)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign masked[c] = view & state_q.en[c];
        intc_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .TW(THR_W)) i_arb (
            .masked_i (masked[c]),
            .prio_i   (state_q.prio[c]),
            .thr_i    (state_q.thr[c]),
            .valid_o  (win_valid[c]),
            .id_o     (win_id[c]),
            .prio_o   (win_prio[c])
        );
    end

    function automatic logic [31:0] pend_word(logic v, logic [IW-1:0] id);
        logic [31:0] w;
        w = '0;
        w[31] = v;
        w[IW-1:0] = id;
        return w;
    endfunction

    logic               in_chan, ch, pch;
    logic [2:0]         ofs;
    logic [4:0]         psrc;
    logic [NUM_SRC-1:0] wbits, clr;

    always_comb begin
        in_chan = (bus_addr_i[6:4] == 3'd0);
        ch      = bus_addr_i[3];
        ofs     = bus_addr_i[2:0];
        pch     = bus_addr_i[5];
        psrc    = bus_addr_i[4:0];
        wbits   = bus_wdata_i[NUM_SRC-1:0];
        clr     = '0;
        state_d = state_q;

        if (bus_wr_i) begin
            if (in_chan) begin
                case (ofs)
                    OFS_STATUS: clr = wbits;
                    OFS_EN_SET: state_d.en[ch] = state_q.en[ch] | wbits;
                    OFS_EN_CLR: state_d.en[ch] = state_q.en[ch] & ~wbits;
                    OFS_THR:    state_d.thr[ch] = bus_wdata_i[THR_W-1:0];
                    default: ;
                endcase
            end else if (bus_addr_i == ADR_POL) begin
                state_d.pol = wbits;
            end else if (bus_addr_i == ADR_SSEL) begin
                state_d.ssel = wbits;
            end else if (bus_addr_i[6] && (int'(psrc) < NUM_SRC)) begin
                state_d.prio[pch][psrc[IW-1:0]] = bus_wdata_i[PRIO_W-1:0];
            end
        end

        state_d.latch = (state_q.latch & ~clr) | level;

        if (bus_rd_i) begin
            state_d.rdata = '0;
            if (in_chan) begin
                case (ofs)
                    OFS_MASKED: state_d.rdata[NUM_SRC-1:0] = masked[ch];
                    OFS_STATUS: state_d.rdata[NUM_SRC-1:0] = view;
                    OFS_EN_SET,
                    OFS_EN_CLR: state_d.rdata[NUM_SRC-1:0] = state_q.en[ch];
                    OFS_CUR:    state_d.rdata = pend_word(win_valid[ch], win_id[ch]);
                    OFS_ACK: begin
                        state_d.rdata = pend_word(win_valid[ch], win_id[ch]);
                        if (win_valid[ch]) begin
                            state_d.saved[ch] = state_q.thr[ch];
                            state_d.thr[ch]   = THR_W'(win_prio[ch]);
                        end
                    end
                    OFS_END: begin
                        state_d.rdata[THR_W-1:0] = state_q.saved[ch];
                        state_d.thr[ch]          = state_q.saved[ch];
                    end
                    default:    state_d.rdata[THR_W-1:0] = state_q.thr[ch];
                endcase
            end else if (bus_addr_i == ADR_POL) begin
                state_d.rdata[NUM_SRC-1:0] = state_q.pol;
            end else if (bus_addr_i == ADR_SSEL) begin
                state_d.rdata[NUM_SRC-1:0] = state_q.ssel;
            end else if (bus_addr_i[6] && (int'(psrc) < NUM_SRC)) begin
                state_d.rdata[PRIO_W-1:0] = state_q.prio[pch][psrc[IW-1:0]];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q       <= '0;
            state_q.pol   <= '1;
            state_q.thr   <= {NUM_CH{THR_RST}};
            state_q.saved <= {NUM_CH{THR_RST}};
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata_o = state_q.rdata;
    assign irq_o       = win_valid[CH_NORM];
    assign fiq_o       = win_valid[CH_FAST];
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int N  = 32,
    parameter int PW = 3,
    parameter int TW = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic [6:0]         bus_addr_i,
    input logic [31:0]        bus_wdata_i,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [N-1:0]       level_i,
    input logic [N-1:0]       latch_i,
    input logic [1:0][N-1:0]  en_i,
    input logic [1:0][TW-1:0] thr_i,
    input logic [1:0][TW-1:0] saved_i,
    input logic [1:0][PW-1:0] win_prio_i
);
    assert_latch_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (($past(level_i) & ~latch_i) == '0));

    assert_enable_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 7'h02)
        |=> ((en_i[0] & $past(bus_wdata_i[N-1:0])) == $past(bus_wdata_i[N-1:0])));

    assert_below_thr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (TW'(win_prio_i[0]) < thr_i[0]));

    assert_fast_below_thr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fiq_o |-> (TW'(win_prio_i[1]) < thr_i[1]));

    assert_ack_swap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && !bus_wr_i && bus_addr_i == 7'h05 && irq_o)
        |=> (saved_i[0] == $past(thr_i[0]) && thr_i[0] == TW'($past(win_prio_i[0]))));

    assert_end_restore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && !bus_wr_i && bus_addr_i == 7'h06) |=> (thr_i[0] == $past(saved_i[0])));

    assert_fast_end_restore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && !bus_wr_i && bus_addr_i == 7'h0E) |=> (thr_i[1] == $past(saved_i[1])));
endmodule

bind intc_top intc_checker #(.N(NUM_SRC), .PW(PRIO_W), .TW(THR_W)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .level_i     (level),
    .latch_i     (state_q.latch),
    .en_i        (state_q.en),
    .thr_i       (state_q.thr),
    .saved_i     (state_q.saved),
    .win_prio_i  (win_prio)
);

// File: tb/test_intc_top.sv
module test_intc_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [N-1:0] src_i = '0;
    logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
    logic [6:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o, fiq_o;

    intc_top i_intc_top (.*);

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // reference model
    logic [N-1:0] m_pol, m_ssel, m_latch;
    logic [N-1:0] m_en [2];
    logic [3:0]   m_thr [2], m_saved [2];
    logic [2:0]   m_prio [2][N];

    function automatic logic [N-1:0] f_level();
        return src_i ^ ~m_pol;
    endfunction

    function automatic logic [N-1:0] f_view();
        return (m_ssel & m_latch) | (~m_ssel & f_level());
    endfunction

    function automatic logic [31:0] f_cur(int c, output logic [2:0] wp);
        logic [N-1:0] mk;
        logic found;
        int id;
        mk = f_view() & m_en[c];
        found = 1'b0; id = 0; wp = '0;
        for (int i = 0; i < N; i++) begin
            if (mk[i] && ({1'b0, m_prio[c][i]} < m_thr[c]) && (!found || m_prio[c][i] < wp)) begin
                found = 1'b1; id = i; wp = m_prio[c][i];
            end
        end
        return {found, 26'd0, 5'(id)};
    endfunction

    function automatic string f_req(logic [6:0] a);
        if (a[6]) return "R11";
        if (a == 7'h10) return "R1";
        if (a == 7'h11) return "R2";
        if (a[6:4] != 3'd0) return "R11";
        if (a[3]) return "R10";
        case (a[2:0])
            3'd0: return "R5";
            3'd1: return "R2";
            3'd2, 3'd3: return "R4";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [31:0] f_read(logic [6:0] a);
        logic [2:0] wp;
        int c;
        c = a[3];
        if (a[6:4] == 3'd0) begin
            case (a[2:0])
                3'd0: return 32'(f_view() & m_en[c]);
                3'd1: return 32'(f_view());
                3'd2, 3'd3: return 32'(m_en[c]);
                3'd4, 3'd5: return f_cur(c, wp);
                3'd6: return 32'(m_saved[c]);
                default: return 32'(m_thr[c]);
            endcase
        end
        if (a == 7'h10) return m_pol;
        if (a == 7'h11) return m_ssel;
        if (a[6]) return 32'(m_prio[a[5]][a[4:0]]);
        return '0;
    endfunction

    task automatic check(logic [31:0] got, logic [31:0] exp, string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one bus cycle; called and returns at a falling edge
    task automatic bus(bit wr, bit rd, logic [6:0] a, logic [31:0] w);
        logic [31:0] exp;
        logic [N-1:0] clr, lvl;
        logic [2:0] wp;
        int c;
        bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = w;
        exp = f_read(a);
        lvl = f_level();
        clr = '0;
        c = a[3];
        if (wr) begin
            if (a[6:4] == 3'd0) begin
                case (a[2:0])
                    3'd1: clr = w;
                    3'd2: m_en[c] = m_en[c] | w;
                    3'd3: m_en[c] = m_en[c] & ~w;
                    3'd7: m_thr[c] = w[3:0];
                    default: ;
                endcase
            end else if (a == 7'h10) m_pol = w;
            else if (a == 7'h11) m_ssel = w;
            else if (a[6]) m_prio[a[5]][a[4:0]] = w[2:0];
        end
        if (rd && a[6:4] == 3'd0) begin
            if (a[2:0] == 3'd5) begin
                if (f_cur(c, wp) & 32'h8000_0000) begin
                    m_saved[c] = m_thr[c];
                    m_thr[c] = {1'b0, wp};
                end
            end else if (a[2:0] == 3'd6) begin
                m_thr[c] = m_saved[c];
            end
        end
        m_latch = (m_latch & ~clr) | lvl;
        @(posedge clk_i);
        @(negedge clk_i);
        bus_wr_i = 1'b0; bus_rd_i = 1'b0;
        if (rd) check(bus_rdata_o, exp, f_req(a));
        check(32'(irq_o), {31'd0, f_cur(0, wp)[31]}, "R6");
        check(32'(fiq_o), {31'd0, f_cur(1, wp)[31]}, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        m_pol = '1; m_ssel = '0; m_latch = '0;
        for (int c = 0; c < 2; c++) begin
            m_en[c] = '0; m_thr[c] = 4'd8; m_saved[c] = 4'd8;
            for (int i = 0; i < N; i++) m_prio[c][i] = '0;
        end
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // reset state
        check(32'(irq_o), 32'd0, "R6");
        bus(0, 1, 7'h10, 0);          // R1 polarity all ones
        bus(0, 1, 7'h07, 0);          // R6 threshold 8
        bus(0, 1, 7'h02, 0);          // R4 nothing enabled
        bus(0, 1, 7'h45, 0);          // R11 priority 0

        // R1: inverted polarity makes a low input active
        bus(1, 0, 7'h10, 32'hFFFF_FFFE);
        bus(0, 1, 7'h01, 0);
        bus(1, 0, 7'h10, 32'hFFFF_FFFF);

        // R2 / R3: latched view holds after input drops, clear works
        bus(1, 0, 7'h11, 32'h0000_0010);
        src_i = 32'h0000_0010;
        bus(0, 1, 7'h01, 0);
        src_i = '0;
        bus(0, 1, 7'h01, 0);
        bus(1, 0, 7'h01, 32'h0000_0010);
        bus(0, 1, 7'h01, 0);
        bus(1, 0, 7'h11, 0);

        // R7 tie: sources 3 and 9 at the same priority
        bus(1, 0, 7'h43, 2); bus(1, 0, 7'h49, 2);
        bus(1, 0, 7'h02, 32'h0000_0228);
        src_i = 32'h0000_0208;
        bus(0, 1, 7'h04, 0);
        bus(0, 1, 7'h00, 0);          // R5

        // R8 / R9: source 5 more urgent
        bus(1, 0, 7'h45, 1);
        src_i = 32'h0000_0228;
        bus(0, 1, 7'h05, 0);          // ack 5, threshold becomes 1
        bus(0, 1, 7'h07, 0);
        bus(0, 1, 7'h05, 0);          // nothing eligible: no change
        bus(0, 1, 7'h06, 0);          // end restores 8
        bus(0, 1, 7'h07, 0);

        // R10: fast channel independent
        bus(1, 0, 7'h6C, 0); bus(1, 0, 7'h67, 0);
        bus(1, 0, 7'h0A, 32'h0000_1080);
        src_i = 32'h0000_1080;
        bus(0, 1, 7'h0C, 0);
        bus(0, 1, 7'h0D, 0);
        bus(0, 1, 7'h0F, 0);
        bus(0, 1, 7'h0E, 0);
        bus(1, 0, 7'h0B, 32'h0000_1080);
        bus(0, 1, 7'h0A, 0);

        // random mix
        for (int it = 0; it < 1500; it++) begin
            int k;
            logic [6:0] a;
            logic [31:0] w;
            if ($urandom_range(0, 3) == 0) src_i = $urandom();
            k = $urandom_range(0, 13);
            w = $urandom();
            a = {3'b000, 1'($urandom_range(0, 1)), 3'd0};
            case (k)
                0: bus(1, 0, a | 7'd2, w);
                1: bus(1, 0, a | 7'd3, w & $urandom());
                2: bus(1, 0, a | 7'd7, ($urandom_range(0, 3) == 0) ? 32'(w[3:0]) : 32'd8);
                3: bus(1, 0, a | 7'd1, w);
                4: bus(1, 0, 7'h10, ($urandom_range(0, 3) == 0) ? w : 32'hFFFF_FFFF);
                5: bus(1, 0, 7'h11, w);
                6: bus(1, 0, {2'b10, 5'($urandom_range(0, 31))} | {1'b0, a[3], 5'd0}, 32'($urandom_range(0, 3)));
                7: bus(0, 1, a | 7'd5, 0);
                8: bus(0, 1, a | 7'd6, 0);
                9: bus(0, 1, a | 7'd4, 0);
                10: bus(0, 1, a | 7'($urandom_range(0, 3)), 0);
                11: bus(0, 1, 7'($urandom_range(7'h10, 7'h7F)), 0);
                12: bus(0, 1, a | 7'd7, 0);
                default: bus(0, 0, 0, 0);
            endcase
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule